// File: doc/BRIEF.md
# Fetch-Boundary Interrupt Controller

This block gathers interrupt requests from a small set of sources and decides when the instruction sequencer should take one. Each source is watched for a rising edge, and each edge sets a sticky cause bit. Interrupts are taken only when the sequencer fetches a new instruction word, never between the slots of a word. When the take signal is high, the sequencer discards the word it fetched. In its place it runs a call to address zero of the home page and pushes the current address onto the return stack. The block itself only raises the take signal for that fetch.

The cause bits form the low field of the configuration register, one bit per source. Service code reads the configuration register to find the cause. It then writes the register to acknowledge the interrupt. The first write during service ends the service, so a new interrupt can be taken at the very next fetch. The low address bits of every configuration write select which cause bits are cleared, whether or not an interrupt is in service. Bits above the cause field are plain settings loaded by each write. Saving and restoring registers and stacks is the job of the service code, not of this block.

Top module: `fetch_irq_ctrl`

## Requirements
- R1: `take_o` is high only in a cycle where `fetch_i` is high, at least one cause bit is set, and no interrupt is in service. In that same cycle the sequencer replaces the fetched word with the vector call.
- R2: Cause bit i is set on the clock edge that sees a rising edge on `src_i[i]`. The edge is measured against the value sampled at the previous edge, and the bit stays set until it is cleared. A source held high does not set the bit again after a clear.
- R3: Bit i of `cause_o` reflects cause bit i, so bit 0 belongs to source 0. The same bits make up `cfg_rdata_o[N_SRC-1:0]` when the register is read.
- R4: After a take, the block is in service, and `take_o` stays low on every later fetch until an acknowledging write.
- R5: The first configuration write in service (`cfg_wr_i` high) ends the service on that clock edge, so a fetch in the next cycle can take a pending interrupt at once. A fetch in the same cycle as the acknowledging write does not take.
- R6: Every configuration write clears cause bit i for which `cfg_waddr_i[i]` is 1, whether or not an interrupt is in service. Address bits of 0 leave their cause bits unchanged.
- R7: If a rising edge of source i and a write clearing bit i fall on the same edge, bit i stays set.
- R8: Every write loads `cfg_wdata_i[CFG_W-1:N_SRC]` into the settings field. A cycle with `cfg_rd_i` high loads {settings, cause bits} into `cfg_rdata_o` on the next edge. Otherwise `cfg_rdata_o` holds its value.
- R9: On a clock edge with `rst_n` low, the cause bits, the service state, the settings and `cfg_rdata_o` all become zero, and `take_o` is low even while `fetch_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | N_SRC | Interrupt request lines, one per source |
| fetch_i | input | 1 | Instruction-word fetch strobe from the sequencer |
| cfg_rd_i | input | 1 | Configuration register read strobe |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_waddr_i | input | N_SRC | Low address bits of the write, a clear mask |
| cfg_wdata_i | input | CFG_W | Write data for the configuration register |
| take_o | output | 1 | Replace this fetched word with the vector call |
| cause_o | output | N_SRC | Latched cause bits |
| cfg_rdata_o | output | CFG_W | Registered read data {settings, cause} |

## Verification
The assertions check several rules on every cycle:
- A take needs a set cause bit.
- No take follows a take while the service is open.
- A write always closes the service.
- Cause bits stay set unless they are selected for clearing.
- A selected bit with no coinciding edge is cleared.

Other behaviour can only be shown by the bench's scenarios:
- An interrupt taken again on the fetch right after the acknowledge.
- A clear that loses to a coinciding rising edge.
- A held-high source that does not set its bit again.
- The settings and cause fields as they come back through a read.

// File: rtl/irq_pkg.sv
// Package irq_pkg: shared types for the fetch-boundary interrupt controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package irq_pkg;
    typedef enum logic {
        SVC_IDLE = 1'b0,
        SVC_BUSY = 1'b1
    } svc_state_t;
endpackage

// File: rtl/irq_edge_latch.sv
// Module irq_edge_latch: detects rising edges on each request line and holds
// them in sticky cause bits until a configuration write clears them through its
// address mask. A coinciding edge wins over a clear.
// Assumes the request lines are already synchronous to clk.
module irq_edge_latch #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             clr_en_i,
    input  logic [N_SRC-1:0] clr_mask_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] clr;

    // Purpose: flag a rising edge and the bits selected for clearing this cycle.
    always_comb begin
        rise = src_i & ~prev_q;
        clr  = clr_en_i ? clr_mask_i : '0;
    end

    // Purpose: remember the last request levels and update the sticky cause bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= src_i;
            pend_q <= (pend_q & ~clr) | rise;
        end
    end

    assign pend_o = pend_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        // R2: a set bit stays set unless this cycle's write selects it
        assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !(clr_en_i && clr_mask_i[i])) |=> pend_q[i]);
        // R6: a selected bit with no coinciding edge is cleared
        assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en_i && clr_mask_i[i] && !(src_i[i] && !prev_q[i])) |=> !pend_q[i]);
    end
endmodule

// File: rtl/irq_svc_ctrl.sv
// Module irq_svc_ctrl: decides at each word fetch whether to take an interrupt
// and tracks the service window, which closes on the first configuration write.
// Assumes fetch_i is a one-cycle strobe per instruction word.
module irq_svc_ctrl
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_i,
    input  logic any_pend_i,
    input  logic ack_i,
    output logic take_o
);
    svc_state_t state_q;
    svc_state_t state_d;

    // Purpose: request a take on a fetch when a cause is waiting and none is in service.
    always_comb begin
        take_o  = fetch_i && any_pend_i && (state_q == SVC_IDLE);
        state_d = state_q;
        if (take_o) begin
            state_d = SVC_BUSY;
        end else if (state_q == SVC_BUSY && ack_i) begin
            state_d = SVC_IDLE;
        end
    end

    // Purpose: hold the service state across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SVC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R4: no second take while the first is still open
    assert_no_retake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
    // R5: a write during service always closes it
    assert_ack_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SVC_BUSY && ack_i) |=> (state_q == SVC_IDLE));
endmodule

// File: rtl/irq_cfg_reg.sv
// Module irq_cfg_reg: holds the settings field above the cause bits and
// registers the read value {settings, cause} on a read strobe.
// Assumes the caller passes only the settings slice of the write data.
module irq_cfg_reg #(
    parameter int N_SRC = 3,
    parameter int CFG_W = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic                   rd_i,
    input  logic [CFG_W-N_SRC-1:0] set_wdata_i,
    input  logic [N_SRC-1:0]       cause_i,
    output logic [CFG_W-1:0]       rdata_o
);
    localparam int SET_W = CFG_W - N_SRC;

    logic [SET_W-1:0] set_q;
    logic [CFG_W-1:0] rdata_q;

    // Purpose: load settings on each write and capture the read value on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_i) begin
                set_q <= set_wdata_i;
            end
            if (rd_i) begin
                rdata_q <= {set_q, cause_i};
            end
        end
    end

    assign rdata_o = rdata_q;

    // R8: read data only moves after a read strobe
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/fetch_irq_ctrl.sv
// Module fetch_irq_ctrl: top of the fetch-boundary interrupt controller. It ties
// the edge latches, the service control and the configuration register together.
// Assumes the sequencer performs the vector call and stack push when take_o is high.
module fetch_irq_ctrl #(
    parameter int N_SRC = 3,
    parameter int CFG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             fetch_i,
    input  logic             cfg_rd_i,
    input  logic             cfg_wr_i,
    input  logic [N_SRC-1:0] cfg_waddr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             take_o,
    output logic [N_SRC-1:0] cause_o,
    output logic [CFG_W-1:0] cfg_rdata_o
);
    logic [N_SRC-1:0] pend;

    irq_edge_latch #(.N_SRC(N_SRC)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .clr_en_i   (cfg_wr_i),
        .clr_mask_i (cfg_waddr_i),
        .pend_o     (pend)
    );

    irq_svc_ctrl u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_i    (fetch_i),
        .any_pend_i (|pend),
        .ack_i      (cfg_wr_i),
        .take_o     (take_o)
    );

    irq_cfg_reg #(.N_SRC(N_SRC), .CFG_W(CFG_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (cfg_wr_i),
        .rd_i        (cfg_rd_i),
        .set_wdata_i (cfg_wdata_i[CFG_W-1:N_SRC]),
        .cause_i     (pend),
        .rdata_o     (cfg_rdata_o)
    );

    assign cause_o = pend;

    // R1: a take needs a fetch and a latched cause
    assert_take_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (fetch_i && (cause_o != '0)));
endmodule

// File: tb/test_fetch_irq_ctrl.sv
module test_fetch_irq_ctrl;
    localparam int N = 3;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] src;
    logic         fetch, rd, wr;
    logic [N-1:0] waddr;
    logic [W-1:0] wdata;
    logic         take;
    logic [N-1:0] cause;
    logic [W-1:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fetch_irq_ctrl #(.N_SRC(N), .CFG_W(W)) i_fetch_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .fetch_i(fetch),
        .cfg_rd_i(rd), .cfg_wr_i(wr), .cfg_waddr_i(waddr), .cfg_wdata_i(wdata),
        .take_o(take), .cause_o(cause), .cfg_rdata_o(rdata)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // fields: src[11:9] fetch[8] wr[7] addr[6:4] take[3] cause[2:0]
    localparam int NV = 19;
    localparam logic [11:0] VEC [NV] = '{
        12'b000_0_0_000_0_000, // idle
        12'b001_0_0_000_0_000, // R2 source 0 rises
        12'b001_1_0_000_1_001, // R1 take at fetch
        12'b001_1_0_000_0_001, // R4 no retake in service
        12'b011_0_0_000_0_001, // R2 source 1 rises
        12'b011_0_1_001_0_011, // R5/R6 ack, clear bit 0
        12'b011_1_0_000_1_010, // R5 immediate retake
        12'b000_0_1_000_0_010, // R6 ack, mask zero keeps bits
        12'b000_0_1_010_0_010, // R6 clear outside service
        12'b000_1_0_000_0_000, // R1 nothing pending, no take
        12'b100_0_1_100_0_000, // R7 edge and clear together
        12'b100_1_0_000_1_100, // R7 bit survived, take
        12'b100_0_1_100_0_100, // R6 ack and clear bit 2
        12'b100_1_0_000_0_000, // R2 held level does not re-set
        12'b000_0_0_000_0_000,
        12'b100_0_0_000_0_000, // R2 new edge
        12'b100_1_0_000_1_100, // R3 cause bit 2 maps to source 2
        12'b100_1_1_000_0_100, // R5 fetch with ack same cycle: no take
        12'b000_1_0_000_1_100  // R5 next fetch takes
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src = '0; fetch = 0; rd = 0; wr = 0; waddr = '0; wdata = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        fetch = 1'b1;
        #1;
        check("R9 reset take", W'(take), '0);
        check("R9 reset cause", W'(cause), '0);
        check("R9 reset rdata", rdata, '0);
        fetch = 1'b0;
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            src   = VEC[k][11:9];
            fetch = VEC[k][8];
            wr    = VEC[k][7];
            waddr = VEC[k][6:4];
            #2;
            check($sformatf("R1/R4/R5 take vec %0d", k), W'(take), W'(VEC[k][3]));
            check($sformatf("R2/R3/R6/R7 cause vec %0d", k), W'(cause), W'(VEC[k][2:0]));
        end

        // R8: settings write then read; state is in service with cause 100
        @(negedge clk);
        fetch = 0; wr = 1; waddr = '0; wdata = 20'hABCD8;
        @(negedge clk);
        wr = 0; rd = 1; wdata = '0;
        @(negedge clk);
        rd = 0;
        #1;
        check("R8 read settings+cause", rdata, {20'hABCD8 >> 3, 3'b100} & 20'hFFFFF);
        check("R3 read cause field", W'(rdata[2:0]), W'(3'b100));
        @(negedge clk);
        wr = 1; wdata = 20'h12340; waddr = 3'b100;
        @(negedge clk);
        wr = 0;
        #1;
        check("R8 rdata holds without read", rdata, {20'hABCD8 >> 3, 3'b100} & 20'hFFFFF);
        check("R6 cleared by write", W'(cause), '0);

        // R9: reset in mid-run
        @(negedge clk);
        src = 3'b001;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        fetch = 1;
        #1;
        check("R9 mid-run take", W'(take), '0);
        check("R9 mid-run cause", W'(cause), '0);
        check("R9 mid-run rdata", rdata, '0);
        fetch = 0; src = '0; rst_n = 1;
        @(negedge clk);
        rd = 1;
        @(negedge clk);
        rd = 0;
        #1;
        check("R9 settings cleared", rdata, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule